// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps transitions on a set of external pins against a shared free-running timebase. Every channel brings its pin into the clock domain, looks for the transition type that software picked, and when one arrives copies the current timebase count into that channel's capture register. Software finds the pulse width or period of a signal by subtracting two captured counts.

A valid edge sets the channel's flag. The flag, gated by an enable bit, drives the channel's interrupt line. A channel can instead hand its capture to an external transfer engine. It raises a request line and holds it until the engine acknowledges. If a second edge lands before the first value has been taken, the new count replaces the old one and a sticky overrun bit records the loss.

Each channel runs a three-state machine. CH_EMPTY means no unread value. CH_HELD means an unread value is waiting for software. CH_XFER means an unread value is waiting for the transfer engine. The transitions are as follows. From CH_EMPTY, a valid edge goes to CH_XFER when transfer is enabled and to CH_HELD otherwise. From CH_HELD, a valid edge goes to the same pair of states, and a capture read returns to CH_EMPTY. From CH_XFER, a valid edge goes to the same pair, and an acknowledge or a capture read returns to CH_EMPTY. When an edge and a consume arrive in the same cycle, the edge wins.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset every capture register reads 0, every control word reads 0, and all interrupt and request outputs are low.
- R2: With edge select 00 (disabled), pin transitions change no capture register, no flag and no state.
- R3: With edge select 01, a rising pin transition captures and sets the flag, and a falling one does neither.
- R4: With edge select 10, a falling pin transition captures and sets the flag, and a rising one does neither.
- R5: With edge select 11, both rising and falling pin transitions capture and set the flag.
- R6: The pin is sampled by two synchroniser flops and one history flop. A pin change that is first sampled at clock edge k is stored at clock edge k+2, and the stored value is the timebase input present during the cycle before that edge.
- R7: A valid edge sets the flag (control bit 4). Writing 0 to bit 4 clears the flag, and writing 1 leaves it unchanged. If an edge and a clearing write fall in the same cycle, the flag ends up set.
- R8: The interrupt output of a channel is high exactly when its flag and its interrupt enable (control bit 2) are both 1.
- R9: A valid edge while the channel holds an unread value overwrites the capture and sets the sticky overrun bit (control bit 5). Reading the capture address consumes the value and clears the held bit (control bit 6). Writing 0 to bit 5 clears overrun. An edge on an empty channel never sets overrun.
- R10: With transfer enable (control bit 3) set, a valid edge raises the channel's request line. The line stays high until the acknowledge input for that channel is seen, and then it drops and the channel becomes empty with its capture unchanged.
- R11: Channels are independent: an edge on one pin changes no other channel's flag, capture or state.
- R12: Register map: capture of channel n at address n (read-only, writes ignored), control of channel n at address 8+n. Control bits [1:0] are the edge select. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbase_i | input | 16 | Shared timebase count |
| cap_pin_i | input | 4 | Asynchronous capture pins, one per channel |
| bus_addr_i | input | 4 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; consumes a capture value when it reads one |
| bus_wdata_i | input | 6 | Write data for control bits [5:0] |
| bus_rdata_o | output | 16 | Read data for the current address (combinational) |
| irq_o | output | 4 | Per-channel interrupt |
| xfer_req_o | output | 4 | Per-channel transfer request |
| xfer_ack_i | input | 4 | Per-channel transfer acknowledge |

## Verification
The assertions check several properties on every cycle. A capture register changes only in the cycle after a qualified edge, and it never changes while its channel is disabled. A qualified edge always leaves the flag set. An edge on a held channel always leaves the overrun bit set. A request rises only with transfer enabled and stays high until it is acknowledged or consumed. The interrupt line never rises without the flag. Only the bench's scenarios can show the remaining behaviour: the captured value equals the timebase two edges after the pin is first sampled, the edge polarity filter works, writes of 0 and 1 to the flag and overrun bits act differently, and neighbouring channels and unmapped addresses are left alone.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        CH_EMPTY = 2'b00,
        CH_HELD  = 2'b01,
        CH_XFER  = 2'b10
    } ch_state_e;

    // control word layout
    localparam int CTL_ESEL_LO = 0;
    localparam int CTL_IEN     = 2;
    localparam int CTL_XEN     = 3;
    localparam int CTL_FLAG    = 4;
    localparam int CTL_OVR     = 5;
    localparam int CTL_HELD    = 6;
    localparam int CTL_BITS    = 7;
    localparam int CTL_WBITS   = 6;

endpackage

// File: rtl/ecu_sync_edge.sv
module ecu_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        rise_o = sync_q[STAGES-1] & ~last_q;
        fall_o = ~sync_q[STAGES-1] & last_q;
    end

endmodule

// File: rtl/ecu_channel.sv
module ecu_channel
    import ecu_pkg::*;
#(
    parameter int TB_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic [TB_W-1:0]      tbase_i,
    input  logic                 ctl_we_i,
    input  logic [CTL_WBITS-1:0] ctl_wdata_i,
    input  logic                 cap_rd_i,
    input  logic                 ack_i,
    output logic [TB_W-1:0]      cap_o,
    output logic [CTL_BITS-1:0]  ctl_o,
    output logic                 evt_o,
    output logic                 req_o,
    output logic                 irq_o
);

    edge_sel_e       esel_q;
    logic            ien_q;
    logic            xen_q;
    logic            flag_q;
    logic            ovr_q;
    logic [TB_W-1:0] cap_q;
    ch_state_e       st_q;
    ch_state_e       st_d;
    logic            evt;
    logic            consume;

    // edge qualification
    always_comb begin
        unique case (esel_q)
            EDGE_OFF:  evt = 1'b0;
            EDGE_RISE: evt = rise_i;
            EDGE_FALL: evt = fall_i;
            EDGE_ANY:  evt = rise_i | fall_i;
            default:   evt = 1'b0;
        endcase
    end

    always_comb consume = cap_rd_i | ((st_q == CH_XFER) & ack_i);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_EMPTY;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_EMPTY: begin
                if (evt) st_d = xen_q ? CH_XFER : CH_HELD;
            end
            CH_HELD: begin
                if (evt)          st_d = xen_q ? CH_XFER : CH_HELD;
                else if (consume) st_d = CH_EMPTY;
            end
            CH_XFER: begin
                if (evt)          st_d = xen_q ? CH_XFER : CH_HELD;
                else if (consume) st_d = CH_EMPTY;
            end
            default: st_d = CH_EMPTY;
        endcase
    end

    // capture, configuration and sticky bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            esel_q <= EDGE_OFF;
            ien_q  <= 1'b0;
            xen_q  <= 1'b0;
            flag_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (evt) cap_q <= tbase_i;
            if (ctl_we_i) begin
                esel_q <= edge_sel_e'(ctl_wdata_i[CTL_ESEL_LO +: 2]);
                ien_q  <= ctl_wdata_i[CTL_IEN];
                xen_q  <= ctl_wdata_i[CTL_XEN];
            end
            if (evt)                                flag_q <= 1'b1;
            else if (ctl_we_i && !ctl_wdata_i[CTL_FLAG]) flag_q <= 1'b0;
            if (evt && st_q != CH_EMPTY && !consume) ovr_q <= 1'b1;
            else if (ctl_we_i && !ctl_wdata_i[CTL_OVR])  ovr_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        cap_o = cap_q;
        evt_o = evt;
        req_o = (st_q == CH_XFER);
        irq_o = flag_q & ien_q;
        ctl_o = '0;
        ctl_o[CTL_ESEL_LO +: 2] = esel_q;
        ctl_o[CTL_IEN]          = ien_q;
        ctl_o[CTL_XEN]          = xen_q;
        ctl_o[CTL_FLAG]         = flag_q;
        ctl_o[CTL_OVR]          = ovr_q;
        ctl_o[CTL_HELD]         = (st_q != CH_EMPTY);
    end

endmodule

// File: rtl/ecu_regs.sv
module ecu_regs
    import ecu_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int TB_W = 16,
    parameter int AW   = 4
) (
    input  logic [AW-1:0]                     addr_i,
    input  logic                              wr_i,
    input  logic                              rd_i,
    input  logic [NCH-1:0][TB_W-1:0]          cap_i,
    input  logic [NCH-1:0][CTL_BITS-1:0]      ctl_i,
    output logic [NCH-1:0]                    ctl_we_o,
    output logic [NCH-1:0]                    cap_rd_o,
    output logic [TB_W-1:0]                   rdata_o
);

    logic          is_ctl;
    logic [AW-2:0] off;

    always_comb begin
        is_ctl = addr_i[AW-1];
        off    = addr_i[AW-2:0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        always_comb begin
            ctl_we_o[g] = wr_i & is_ctl & (int'(off) == g);
            cap_rd_o[g] = rd_i & ~is_ctl & (int'(off) == g);
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int n = 0; n < NCH; n++) begin
            if (int'(off) == n) rdata_o = is_ctl ? TB_W'(ctl_i[n]) : cap_i[n];
        end
    end

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecu_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int TB_W        = 16,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TB_W-1:0]      tbase_i,
    input  logic [NCH-1:0]       cap_pin_i,
    input  logic [AW-1:0]        bus_addr_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [CTL_WBITS-1:0] bus_wdata_i,
    output logic [TB_W-1:0]      bus_rdata_o,
    output logic [NCH-1:0]       irq_o,
    output logic [NCH-1:0]       xfer_req_o,
    input  logic [NCH-1:0]       xfer_ack_i
);

    logic [NCH-1:0]                rise_w;
    logic [NCH-1:0]                fall_w;
    logic [NCH-1:0]                evt_w;
    logic [NCH-1:0]                ctl_we_w;
    logic [NCH-1:0]                cap_rd_w;
    logic [NCH-1:0][TB_W-1:0]      cap_w;
    logic [NCH-1:0][CTL_BITS-1:0]  ctl_w;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ecu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (cap_pin_i[g]),
            .rise_o (rise_w[g]),
            .fall_o (fall_w[g])
        );

        ecu_channel #(.TB_W(TB_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .rise_i      (rise_w[g]),
            .fall_i      (fall_w[g]),
            .tbase_i     (tbase_i),
            .ctl_we_i    (ctl_we_w[g]),
            .ctl_wdata_i (bus_wdata_i),
            .cap_rd_i    (cap_rd_w[g]),
            .ack_i       (xfer_ack_i[g]),
            .cap_o       (cap_w[g]),
            .ctl_o       (ctl_w[g]),
            .evt_o       (evt_w[g]),
            .req_o       (xfer_req_o[g]),
            .irq_o       (irq_o[g])
        );
    end

    ecu_regs #(.NCH(NCH), .TB_W(TB_W), .AW(AW)) u_regs (
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .rd_i     (bus_rd_i),
        .cap_i    (cap_w),
        .ctl_i    (ctl_w),
        .ctl_we_o (ctl_we_w),
        .cap_rd_o (cap_rd_w),
        .rdata_o  (bus_rdata_o)
    );

endmodule

// File: rtl/ecu_checker.sv
module ecu_checker
    import ecu_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int TB_W = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NCH-1:0]                 evt,
    input logic [NCH-1:0]                 cap_rd,
    input logic [NCH-1:0]                 req,
    input logic [NCH-1:0]                 ack,
    input logic [NCH-1:0]                 irq,
    input logic [NCH-1:0][CTL_BITS-1:0]   ctl,
    input logic [NCH-1:0][TB_W-1:0]       cap
);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_DISABLED_KEEPS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl[i][1:0] == 2'b00) |=> $stable(cap[i])); // R2

        AST_CAPTURE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            !evt[i] |=> $stable(cap[i])); // R6

        AST_FLAG_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> ctl[i][CTL_FLAG]); // R7

        AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (ctl[i][CTL_FLAG] && ctl[i][CTL_IEN])); // R8

        AST_OVERRUN_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && ctl[i][CTL_HELD] && !cap_rd[i] && !(req[i] && ack[i])) |=> ctl[i][CTL_OVR]); // R9

        AST_REQ_NEEDS_XEN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req[i]) |-> $past(ctl[i][CTL_XEN])); // R10

        AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (req[i] && !ack[i] && !cap_rd[i] && !evt[i]) |=> req[i]); // R10
    end

endmodule

bind edge_capture_unit ecu_checker #(.NCH(NCH), .TB_W(TB_W)) u_ecu_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_w),
    .cap_rd (cap_rd_w),
    .req    (xfer_req_o),
    .ack    (xfer_ack_i),
    .irq    (irq_o),
    .ctl    (ctl_w),
    .cap    (cap_w)
);

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tb_cnt;
    logic [3:0]  pins = '0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [5:0]  wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  irq;
    logic [3:0]  req;
    logic [3:0]  ack = '0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) tb_cnt <= 16'h0100;
        else        tb_cnt <= tb_cnt + 16'd1;
    end

    edge_capture_unit i_edge_capture_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .tbase_i     (tb_cnt),
        .cap_pin_i   (pins),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .xfer_req_o  (req),
        .xfer_ack_i  (ack)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [5:0] d);
        @(negedge clk);
        addr = 4'(a); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input int a, input bit consume, output logic [15:0] d);
        @(negedge clk);
        addr = 4'(a); rd = consume;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic ctl_rd(input int ch, output logic [15:0] d);
        bus_rd(8 + ch, 1'b0, d);
    endtask

    // keep sticky bits (write 1)
    task automatic cfg(input int ch, input logic [1:0] es, input bit ien, input bit xen);
        bus_wr(8 + ch, {2'b11, xen, ien, es});
    endtask

    // clear sticky bits (write 0)
    task automatic clr(input int ch, input logic [1:0] es, input bit ien, input bit xen);
        bus_wr(8 + ch, {2'b00, xen, ien, es});
    endtask

    task automatic pin_set(input int ch, input logic v, output logic [15:0] exp);
        @(negedge clk);
        pins[ch] = v;
        exp = tb_cnt + 16'd2;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        ctl_rd(0, d);     check("R1 ctl0 after reset", d, 16'h0);
        bus_rd(2, 0, d);  check("R1 cap2 after reset", d, 16'h0);
        check("R1 irq after reset", irq, 4'h0);
        check("R1 req after reset", req, 4'h0);
    endtask

    task automatic t_disabled();
        logic [15:0] d, e;
        cfg(0, 2'b00, 1'b1, 1'b0);
        pin_set(0, 1'b1, e);
        ctl_rd(0, d);     check("R2 ctl0 unchanged", d, 16'h0004);
        bus_rd(0, 0, d);  check("R2 cap0 unchanged", d, 16'h0);
        check("R2 irq0 low", irq[0], 1'b0);
        pin_set(0, 1'b0, e);
    endtask

    task automatic t_rising();
        logic [15:0] d, e, e2;
        cfg(1, 2'b01, 1'b0, 1'b0);
        pin_set(1, 1'b1, e);
        ctl_rd(1, d);     check("R3 flag on rise", d[4], 1'b1);
        bus_rd(1, 1, d);  check("R6 R3 captured count", d, e);
        clr(1, 2'b01, 1'b0, 1'b0);
        pin_set(1, 1'b0, e2);
        ctl_rd(1, d);     check("R3 no flag on fall", d[4], 1'b0);
        bus_rd(1, 0, d);  check("R3 cap kept on fall", d, e);
    endtask

    task automatic t_falling();
        logic [15:0] d, e;
        cfg(2, 2'b10, 1'b0, 1'b0);
        pin_set(2, 1'b1, e);
        ctl_rd(2, d);     check("R4 no flag on rise", d[4], 1'b0);
        pin_set(2, 1'b0, e);
        ctl_rd(2, d);     check("R4 flag on fall", d[4], 1'b1);
        bus_rd(2, 1, d);  check("R4 R6 captured count", d, e);
        clr(2, 2'b10, 1'b0, 1'b0);
    endtask

    task automatic t_both();
        logic [15:0] d, e1, e2;
        cfg(3, 2'b11, 1'b0, 1'b0);
        pin_set(3, 1'b1, e1);
        bus_rd(3, 1, d);  check("R5 capture on rise", d, e1);
        clr(3, 2'b11, 1'b0, 1'b0);
        pin_set(3, 1'b0, e2);
        ctl_rd(3, d);     check("R5 flag on fall", d[4], 1'b1);
        bus_rd(3, 1, d);  check("R5 capture on fall", d, e2);
        clr(3, 2'b11, 1'b0, 1'b0);
    endtask

    task automatic t_irq();
        logic [15:0] d, e;
        cfg(1, 2'b11, 1'b1, 1'b0);
        pin_set(1, 1'b1, e);
        check("R8 irq with flag and enable", irq[1], 1'b1);
        cfg(1, 2'b11, 1'b0, 1'b0);
        check("R8 irq masked", irq[1], 1'b0);
        ctl_rd(1, d);     check("R7 write 1 keeps flag", d[4], 1'b1);
        cfg(1, 2'b11, 1'b1, 1'b0);
        check("R8 irq unmasked", irq[1], 1'b1);
        clr(1, 2'b11, 1'b1, 1'b0);
        ctl_rd(1, d);     check("R7 write 0 clears flag", d[4], 1'b0);
        check("R8 irq after clear", irq[1], 1'b0);
        bus_rd(1, 1, d);
    endtask

    task automatic t_overrun();
        logic [15:0] d, e1, e2, e3;
        clr(0, 2'b11, 1'b0, 1'b0);
        pin_set(0, 1'b1, e1);
        pin_set(0, 1'b0, e2);
        bus_rd(0, 0, d);  check("R9 overwritten value", d, e2);
        ctl_rd(0, d);     check("R9 overrun and held", d[6:5], 2'b11);
        bus_rd(0, 1, d);
        ctl_rd(0, d);     check("R9 read clears held, overrun sticky", d[6:5], 2'b01);
        clr(0, 2'b11, 1'b0, 1'b0);
        ctl_rd(0, d);     check("R9 write 0 clears overrun", d[5], 1'b0);
        pin_set(0, 1'b1, e3);
        ctl_rd(0, d);     check("R9 no overrun when empty", d[6:5], 2'b10);
        bus_rd(0, 1, d);
        clr(0, 2'b11, 1'b0, 1'b0);
    endtask

    task automatic t_xfer();
        logic [15:0] d, e;
        clr(2, 2'b01, 1'b0, 1'b1);
        pin_set(2, 1'b1, e);
        check("R10 request raised", req[2], 1'b1);
        repeat (3) @(negedge clk);
        check("R10 request held", req[2], 1'b1);
        ack[2] = 1'b1;
        @(negedge clk);
        ack[2] = 1'b0;
        check("R10 request dropped", req[2], 1'b0);
        ctl_rd(2, d);     check("R10 channel empty after ack", d[6], 1'b0);
        bus_rd(2, 0, d);  check("R10 capture kept", d, e);
        clr(2, 2'b01, 1'b0, 1'b0);
    endtask

    task automatic t_indep();
        logic [15:0] d, e, c0;
        for (int ch = 0; ch < 4; ch++) begin
            clr(ch, 2'b11, 1'b0, 1'b0);
            bus_rd(ch, 1, d);
        end
        bus_rd(0, 0, c0);
        pin_set(3, 1'b1, e);
        for (int ch = 0; ch < 3; ch++) begin
            ctl_rd(ch, d); check("R11 other flag clear", d[6:4], 3'b000);
        end
        bus_rd(0, 0, d);  check("R11 other capture kept", d, c0);
        bus_rd(3, 0, d);  check("R11 own capture", d, e);
    endtask

    task automatic t_map();
        logic [15:0] d, c3;
        bus_rd(3, 0, c3);
        bus_wr(3, 6'h3f);
        bus_rd(3, 0, d);  check("R12 capture write ignored", d, c3);
        bus_rd(5, 0, d);  check("R12 unmapped low reads 0", d, 16'h0);
        bus_rd(12, 0, d); check("R12 unmapped high reads 0", d, 16'h0);
        cfg(2, 2'b10, 1'b1, 1'b1);
        ctl_rd(2, d);     check("R12 control layout", d, 16'h000e);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_rising();
        t_falling();
        t_both();
        t_irq();
        t_overrun();
        t_xfer();
        t_indep();
        t_map();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule